// File: doc/BRIEF.md
# Single-Bus Accumulator Processor

This block is a small 8-bit accumulator processor in which every register transfer travels over one shared data bus. Five sources can drive that bus: the program counter, a constant generator, the accumulator, an input port and the internal memory. In any cycle at most one of them is enabled. A hardwired microsequencer issues the output-enable and load strobes, so every instruction runs as a short chain of bus transfers: fetch the opcode, fetch an operand byte if there is one, then act. The ALU takes the accumulator and an operand buffer register and can add, subtract or exclusive-or. Its result goes back into the accumulator. A zero detector watches the accumulator and steers the conditional jump.

The block is used in two phases. While `run` is low and the core sits idle after reset, a loader port writes the program and data into the internal memory. When `run` rises, execution starts at address 0 and continues until a halt opcode or an undefined opcode stops the core. Reset clears the registers but not the memory.

Top module: `bac_cpu`

## Requirements
- R1: After reset the accumulator reads 0, `eqz_o` is 1 and `halted_o` is 0. While `run` stays low the core executes nothing. In that state, loader writes (`ld_we`, `ld_addr`, `ld_data`) store bytes into memory, and execution starts from address 0 once `run` is seen high.
- R2: Opcode 0x10 followed by an address byte A writes the accumulator into memory location A and leaves the accumulator unchanged.
- R3: Opcode 0x20 adds the following byte to the accumulator, 0x21 subtracts it (accumulator minus byte), and 0x22 exclusive-ors it in. All arithmetic wraps modulo 256.
- R4: Opcode 0x30 followed by an address byte A loads memory location A into the accumulator.
- R5: Opcode 0x40 followed by a byte A continues execution at address A.
- R6: Opcode 0x41 followed by a byte A continues at A when the accumulator is zero. Otherwise it continues at the byte after A.
- R7: Opcode 0x50 copies `in_port` into the accumulator.
- R8: Single-byte constant operations: 0x60 clears the accumulator, 0x61 adds 1, 0x62 subtracts 1, 0x63 inverts every bit, and 0x64 inverts bit 7.
- R9: Opcode 0x00, and any opcode not listed in R2 to R8, raises `halted_o`. From then on `halted_o` stays 1 and the accumulator stays frozen until reset.
- R10: `eqz_o` is 1 exactly when the accumulator holds zero.
- R11: Every cycle has at most one bus driver. Counted from the clock edge that first samples `run` high, instructions take these numbers of cycles:
  - 0x10, 0x20-0x22 and 0x30: 5 cycles.
  - 0x40, 0x41 and 0x61-0x64: 4 cycles.
  - 0x50 and 0x60: 3 cycles.
  - `halted_o` rises 4 cycles after the halting opcode's fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Start request, sampled while the core is idle |
| ld_we | input | 1 | Loader write strobe, effective only while idle |
| ld_addr | input | AW | Loader write address |
| ld_data | input | DW | Loader write data |
| in_port | input | DW | Input port value read by opcode 0x50 |
| acc_o | output | DW | Accumulator contents |
| eqz_o | output | 1 | Accumulator-is-zero flag |
| halted_o | output | 1 | Core has stopped on a halt or undefined opcode |

## Verification
The core is exercised with whole programs. Each program's final accumulator and its cycle count to halt are compared against an instruction-level model in the bench.

- Random straight-line programs mix the ALU, constant, store, load and input opcodes over random data. They show whether each operation and its operand routing is right.
- A directed countdown loop tells a taken jump from a fall-through. Because it also checks the cycle total, an extra or missing sequencer step shows up.
- Short directed programs cover the remaining cases: subtract wrap-around, inversion of bit 7, a zero result, an undefined opcode, and a long idle period with `run` low. Together they separate halting, freezing and the zero flag.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_F0, ST_F1, ST_E0, ST_E1, ST_E2, ST_HALT
  } seq_state_t;

  typedef enum logic [1:0] {
    ALU_ADD, ALU_SUB, ALU_XOR
  } alu_mode_t;

  // bus drivers and load strobes issued by the sequencer for one cycle
  typedef struct packed {
    logic      oe_pc;
    logic      oe_const;
    logic      oe_acc;
    logic      oe_port;
    logic      oe_mem;
    logic      ld_mar;
    logic      ld_abr;
    logic      ld_acc;
    logic      acc_from_alu;
    logic      ld_ir;
    logic      inc_pc;
    logic      ld_pc;
    logic      we_mem;
    logic [1:0] csel;
    alu_mode_t alu_mode;
  } ctrl_t;

  localparam logic [7:0] OP_HALT = 8'h00;
  localparam logic [7:0] OP_STA  = 8'h10;
  localparam logic [7:0] OP_ADDI = 8'h20;
  localparam logic [7:0] OP_SUBI = 8'h21;
  localparam logic [7:0] OP_XORI = 8'h22;
  localparam logic [7:0] OP_LDA  = 8'h30;
  localparam logic [7:0] OP_JMP  = 8'h40;
  localparam logic [7:0] OP_JZ   = 8'h41;
  localparam logic [7:0] OP_IN   = 8'h50;
  localparam logic [7:0] OP_CLR  = 8'h60;
  localparam logic [7:0] OP_INC  = 8'h61;
  localparam logic [7:0] OP_DEC  = 8'h62;
  localparam logic [7:0] OP_CPL  = 8'h63;
  localparam logic [7:0] OP_FMSB = 8'h64;

  // constant generator selects
  localparam logic [1:0] CS_ZERO = 2'd0;
  localparam logic [1:0] CS_ONE  = 2'd1;
  localparam logic [1:0] CS_ONES = 2'd2;
  localparam logic [1:0] CS_MSB  = 2'd3;

endpackage

// File: rtl/bac_alu.sv
module bac_alu
  import bac_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_mode_t     mode,
  output logic [DW-1:0] y
);

  logic          inv;
  logic [DW-1:0] b_path;

  // subtraction: invert the operand and inject a carry
  assign inv    = (mode == ALU_SUB);
  assign b_path = b ^ {DW{inv}};

  always_comb begin
    if (mode == ALU_XOR) y = a ^ b;
    else                 y = a + b_path + DW'(inv);
  end

endmodule

// File: rtl/bac_ram.sv
module bac_ram #(
  parameter int DW = 8,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/bac_seq.sv
module bac_seq
  import bac_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] ir,
  input  logic          eqz,
  output ctrl_t         ctrl,
  output logic          idle,
  output logic          halted
);

  seq_state_t st_q, st_d;
  logic [7:0] op;

  assign op     = ir[7:0];
  assign idle   = (st_q == ST_IDLE);
  assign halted = (st_q == ST_HALT);

  always_comb begin
    ctrl = '0;
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (run) st_d = ST_F0;
      ST_F0: begin
        ctrl.oe_pc  = 1'b1;
        ctrl.ld_mar = 1'b1;
        st_d        = ST_F1;
      end
      ST_F1: begin
        ctrl.oe_mem = 1'b1;
        ctrl.ld_ir  = 1'b1;
        ctrl.inc_pc = 1'b1;
        st_d        = ST_E0;
      end
      ST_E0: begin
        case (op)
          OP_STA, OP_LDA, OP_ADDI, OP_SUBI, OP_XORI, OP_JMP, OP_JZ: begin
            ctrl.oe_pc  = 1'b1;
            ctrl.ld_mar = 1'b1;
            st_d        = ST_E1;
          end
          OP_IN: begin
            ctrl.oe_port = 1'b1;
            ctrl.ld_acc  = 1'b1;
            st_d         = ST_F0;
          end
          OP_CLR: begin
            ctrl.oe_const = 1'b1;
            ctrl.csel     = CS_ZERO;
            ctrl.ld_acc   = 1'b1;
            st_d          = ST_F0;
          end
          OP_INC, OP_DEC, OP_CPL, OP_FMSB: begin
            ctrl.oe_const = 1'b1;
            ctrl.ld_abr   = 1'b1;
            ctrl.csel     = (op == OP_CPL)  ? CS_ONES :
                            (op == OP_FMSB) ? CS_MSB  : CS_ONE;
            st_d          = ST_E1;
          end
          default: st_d = ST_HALT;
        endcase
      end
      ST_E1: begin
        st_d = ST_F0;
        case (op)
          OP_STA, OP_LDA: begin
            ctrl.oe_mem = 1'b1;
            ctrl.ld_mar = 1'b1;
            ctrl.inc_pc = 1'b1;
            st_d        = ST_E2;
          end
          OP_ADDI, OP_SUBI, OP_XORI: begin
            ctrl.oe_mem = 1'b1;
            ctrl.ld_abr = 1'b1;
            ctrl.inc_pc = 1'b1;
            st_d        = ST_E2;
          end
          OP_JMP: begin
            ctrl.oe_mem = 1'b1;
            ctrl.ld_pc  = 1'b1;
          end
          OP_JZ: begin
            ctrl.oe_mem = eqz;
            ctrl.ld_pc  = eqz;
            ctrl.inc_pc = !eqz;
          end
          OP_INC, OP_DEC, OP_CPL, OP_FMSB: begin
            ctrl.ld_acc       = 1'b1;
            ctrl.acc_from_alu = 1'b1;
            ctrl.alu_mode     = (op == OP_DEC) ? ALU_SUB :
                                (op == OP_INC) ? ALU_ADD : ALU_XOR;
          end
          default: st_d = ST_HALT;
        endcase
      end
      ST_E2: begin
        st_d = ST_F0;
        case (op)
          OP_STA: begin
            ctrl.oe_acc = 1'b1;
            ctrl.we_mem = 1'b1;
          end
          OP_LDA: begin
            ctrl.oe_mem = 1'b1;
            ctrl.ld_acc = 1'b1;
          end
          OP_ADDI, OP_SUBI, OP_XORI: begin
            ctrl.ld_acc       = 1'b1;
            ctrl.acc_from_alu = 1'b1;
            ctrl.alu_mode     = (op == OP_SUBI) ? ALU_SUB :
                                (op == OP_XORI) ? ALU_XOR : ALU_ADD;
          end
          default: st_d = ST_HALT;
        endcase
      end
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/bac_cpu.sv
module bac_cpu
  import bac_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [DW-1:0] in_port,
  output logic [DW-1:0] acc_o,
  output logic          eqz_o,
  output logic          halted_o
);

  localparam int NSRC = 5;

  logic [1:0]    rst_sync;
  logic          rst_n_s;
  ctrl_t         ctrl;
  logic          idle;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, abr, acc, bus, konst, mem_rd, alu_y;
  logic [NSRC-1:0] oe_vec;
  logic          mem_we;
  logic [AW-1:0] mem_wa;
  logic [DW-1:0] mem_wd;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  bac_seq #(.DW(DW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (run),
    .ir     (ir),
    .eqz    (eqz_o),
    .ctrl   (ctrl),
    .idle   (idle),
    .halted (halted_o)
  );

  // constant generator
  always_comb begin
    case (ctrl.csel)
      CS_ZERO: konst = '0;
      CS_ONE:  konst = DW'(1);
      CS_ONES: konst = '1;
      default: konst = {1'b1, {(DW-1){1'b0}}};
    endcase
  end

  // shared bus: one enabled source, otherwise zero
  assign oe_vec = {ctrl.oe_mem, ctrl.oe_port, ctrl.oe_acc, ctrl.oe_const, ctrl.oe_pc};

  always_comb begin
    bus = '0;
    if (ctrl.oe_pc)    bus = DW'(pc);
    if (ctrl.oe_const) bus = konst;
    if (ctrl.oe_acc)   bus = acc;
    if (ctrl.oe_port)  bus = in_port;
    if (ctrl.oe_mem)   bus = mem_rd;
  end

  bac_alu #(.DW(DW)) u_alu (
    .a    (acc),
    .b    (abr),
    .mode (ctrl.alu_mode),
    .y    (alu_y)
  );

  // memory write: core store, or loader while idle
  assign mem_we = ctrl.we_mem | (ld_we & idle);
  assign mem_wa = ctrl.we_mem ? mar : ld_addr;
  assign mem_wd = ctrl.we_mem ? bus : ld_data;

  bac_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_wa),
    .wdata (mem_wd),
    .raddr (mar),
    .rdata (mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc  <= '0;
      mar <= '0;
      ir  <= '0;
      abr <= '0;
      acc <= '0;
    end else begin
      if (ctrl.ld_pc)       pc <= bus[AW-1:0];
      else if (ctrl.inc_pc) pc <= pc + AW'(1);
      if (ctrl.ld_mar) mar <= bus[AW-1:0];
      if (ctrl.ld_ir)  ir  <= bus;
      if (ctrl.ld_abr) abr <= bus;
      if (ctrl.ld_acc) acc <= ctrl.acc_from_alu ? alu_y : bus;
    end
  end

  assign acc_o = acc;
  assign eqz_o = (acc == '0);

endmodule

// File: rtl/bac_chk.sv
module bac_chk #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    oe_vec,
  input logic          ld_acc,
  input logic          we_mem,
  input logic          inc_pc,
  input logic          ld_pc,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] acc,
  input logic          halted
);

  p_one_driver_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oe_vec));

  p_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_pc || ld_pc) |=> $stable(pc));

  p_store_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_mem |-> (oe_vec == 5'b00100));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (oe_vec == '0) && !we_mem && !ld_acc);

  p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_acc |=> $stable(acc));

endmodule

bind bac_cpu bac_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_s),
  .oe_vec (oe_vec),
  .ld_acc (ctrl.ld_acc),
  .we_mem (ctrl.we_mem),
  .inc_pc (ctrl.inc_pc),
  .ld_pc  (ctrl.ld_pc),
  .pc     (pc),
  .acc    (acc),
  .halted (halted_o)
);

// File: tb/bac_cpu_tb.sv
`timescale 1ns/1ps
module bac_cpu_tb;

  logic       clk = 1'b0;
  logic       rst_n, run, ld_we;
  logic [7:0] ld_addr, ld_data, in_port;
  logic [7:0] acc_o;
  logic       eqz_o, halted_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] prog [256];

  always #2.5 clk = ~clk;

  bac_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .in_port(in_port), .acc_o(acc_o), .eqz_o(eqz_o),
    .halted_o(halted_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // instruction-level reference: final accumulator and cycles to halt
  task automatic model(input logic [7:0] inv, output logic [7:0] macc, output int mcyc);
    logic [7:0] m [256];
    logic [7:0] pc, op, opd;
    bit done;
    for (int i = 0; i < 256; i++) m[i] = prog[i];
    pc = 0; macc = 0; mcyc = 0; done = 0;
    for (int s = 0; s < 3000 && !done; s++) begin
      op  = m[pc];
      opd = m[pc + 8'd1];
      case (op)
        8'h10: begin m[opd] = macc; pc += 2; mcyc += 5; end
        8'h20: begin macc += opd;   pc += 2; mcyc += 5; end
        8'h21: begin macc -= opd;   pc += 2; mcyc += 5; end
        8'h22: begin macc ^= opd;   pc += 2; mcyc += 5; end
        8'h30: begin macc = m[opd]; pc += 2; mcyc += 5; end
        8'h40: begin pc = opd; mcyc += 4; end
        8'h41: begin pc = (macc == 0) ? opd : pc + 8'd2; mcyc += 4; end
        8'h50: begin macc = inv;      pc += 1; mcyc += 3; end
        8'h60: begin macc = 0;        pc += 1; mcyc += 3; end
        8'h61: begin macc += 1;       pc += 1; mcyc += 4; end
        8'h62: begin macc -= 1;       pc += 1; mcyc += 4; end
        8'h63: begin macc = ~macc;    pc += 1; mcyc += 4; end
        8'h64: begin macc ^= 8'h80;   pc += 1; mcyc += 4; end
        default: begin mcyc += 4; done = 1; end
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; ld_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_prog();
    for (int i = 0; i < 256; i++) begin
      ld_we = 1'b1; ld_addr = 8'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  // start the core and count edges until halted is seen
  task automatic run_prog(output int cyc);
    cyc = 0;
    run = 1'b1;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      run = 1'b0;
      if (halted_o || cyc > 5000) break;
    end
    if (cyc > 5000) chk("watchdog", cyc, 0);
  endtask

  task automatic exec_and_check(input string req, input logic [7:0] inv);
    logic [7:0] macc;
    int mcyc, cyc;
    in_port = inv;
    do_reset();
    load_prog();
    model(inv, macc, mcyc);
    run_prog(cyc);
    chk({req, " acc"}, acc_o, macc);
    chk("R11 cycles", cyc, mcyc);
    chk("R10 eqz", eqz_o, (macc == 0));
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 8'h00;
  endtask

  logic [7:0] ops [11] = '{8'h20, 8'h21, 8'h22, 8'h10, 8'h30, 8'h50,
                           8'h60, 8'h61, 8'h62, 8'h63, 8'h64};

  initial begin
    logic [7:0] a0;
    int cyc;
    void'($urandom(32'd1234));
    rst_n = 1'b0; run = 1'b0; ld_we = 1'b0;
    ld_addr = '0; ld_data = '0; in_port = '0;

    // R1: reset state, idle with run low
    do_reset();
    chk("R1 acc after reset", acc_o, 0);
    chk("R1 eqz after reset", eqz_o, 1);
    chk("R1 halted after reset", halted_o, 0);
    clear_prog();
    prog[0] = 8'h60; // clear, then halt
    load_prog();
    repeat (30) @(negedge clk);
    chk("R1 no execution while run low", halted_o, 0);
    run_prog(cyc);
    chk("R8 clear acc", acc_o, 0);
    chk("R10 eqz on zero", eqz_o, 1);
    chk("R11 clear+halt cycles", cyc, 7);

    // R5 R6 R2 R4: countdown loop with store and load back
    clear_prog();
    prog[8'h00] = 8'h20; prog[8'h01] = 8'h05;
    prog[8'h02] = 8'h62;
    prog[8'h03] = 8'h41; prog[8'h04] = 8'h07;
    prog[8'h05] = 8'h40; prog[8'h06] = 8'h02;
    prog[8'h07] = 8'h10; prog[8'h08] = 8'hC0;
    prog[8'h09] = 8'h20; prog[8'h0A] = 8'h09;
    prog[8'h0B] = 8'h30; prog[8'h0C] = 8'hC0;
    prog[8'h0D] = 8'h22; prog[8'h0E] = 8'h3C;
    prog[8'h0F] = 8'h00;
    prog[8'hC0] = 8'hAA;
    in_port = 8'h00;
    do_reset(); load_prog(); run_prog(cyc);
    chk("R6 R5 R2 R4 loop result", acc_o, 8'h3C);
    chk("R11 loop cycles", cyc, 85);

    // R7 R8 R3: input port, constant ops, subtract wrap
    clear_prog();
    prog[0] = 8'h50; prog[1] = 8'h64; prog[2] = 8'h62; prog[3] = 8'h62;
    prog[4] = 8'h63; prog[5] = 8'h61; prog[6] = 8'h21; prog[7] = 8'h02;
    prog[8] = 8'h00;
    in_port = 8'h81;
    do_reset(); load_prog(); run_prog(cyc);
    chk("R7 R8 R3 const chain", acc_o, 8'hFF);
    chk("R11 const chain cycles", cyc, 32);
    chk("R10 eqz nonzero", eqz_o, 0);

    // R9: undefined opcode halts and freezes
    clear_prog();
    prog[0] = 8'h20; prog[1] = 8'h5A; prog[2] = 8'h77; prog[3] = 8'h61;
    do_reset(); load_prog(); run_prog(cyc);
    chk("R9 undefined halts", cyc, 5 + 4);
    a0 = acc_o;
    repeat (20) @(negedge clk);
    chk("R9 acc frozen", acc_o, 8'h5A);
    chk("R9 acc unchanged", acc_o, a0);
    chk("R9 halted sticky", halted_o, 1);

    // random straight-line programs
    for (int t = 0; t < 24; t++) begin
      int p;
      clear_prog();
      for (int i = 8'hC0; i < 256; i++) prog[i] = 8'($urandom);
      p = 0;
      for (int k = 0; k < 4 + int'($urandom % 10); k++) begin
        logic [7:0] o;
        o = ops[$urandom % 11];
        prog[p] = o; p++;
        if (o == 8'h10 || o == 8'h30) begin prog[p] = 8'hC0 + 8'($urandom % 16); p++; end
        else if (o[7:4] == 4'h2)      begin prog[p] = 8'($urandom); p++; end
      end
      prog[p] = (t % 6 == 5) ? 8'hEE : 8'h00;
      exec_and_check("R2 R3 R4 R7 R8 random", 8'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule